// File: doc/BRIEF.md
# Serial-Fed Stochastic Neuron Layer

This block evaluates one time slice for a layer of bit-stream neurons. The neurons share a single serial weight line and a single serial input line. A value v in the range -1 to +1 travels as a bit stream in which a 1 appears with probability (v+1)/2. Multiplying two such streams therefore needs only an XNOR gate. For each input position, the block first shifts one weight bit per neuron into a weight register. It then samples the shared input bit and XNORs that bit with every neuron's weight bit at once. Each neuron adds its product bit to a private counter.

Thresholding works by overflow. A start pulse preloads every counter with the all-ones count minus that neuron's threshold for this slice. A neuron fires when its counter rolls past all-ones. Once set, the fire flag stays set until the next preload. A new set of thresholds is taken at every start, so an external source with a chosen distribution sets the activation shape. When the last input has been applied, all fire flags are copied into an output register together. A one-cycle done strobe is raised, and the bits are shifted out on one serial line.

One slice takes INPUTS×(NEURONS+1) cycles. This cost comes from delivering the weights serially.

Top module: `stoch_neuron_layer`

## Requirements
- R1: Out of reset, `busy`, `in_phase`, `done` and `out_bit` are all 0.
- R2: Within each input group, the first weight bit driven after the group opens belongs to neuron 0, the next to neuron 1, and so on. One weight bit is sampled per cycle for NEURONS cycles.
- R3: In the cycle after the weight bits of a group, `in_phase` is 1 and `x_in` is sampled. Each neuron's product is `x_in` XNOR its weight bit, and a product of 1 adds one to that neuron's count.
- R4: A neuron fires in a slice exactly when its number of 1 products exceeds its threshold. This follows from preloading the counter with 2^CW−1 minus the threshold and detecting overflow.
- R5: The thresholds on `thr` are sampled only on the start cycle. Neuron k uses bits [k*CW +: CW]. Every slice may use new thresholds.
- R6: `done` is a single-cycle strobe. It is seen exactly INPUTS×(NEURONS+1) cycles after the cycle in which start was accepted, and `busy` falls at the same edge.
- R7: During the `done` cycle, `out_bit` carries neuron 0's result. Neurons 1 to NEURONS−1 follow, one per cycle.
- R8: A start pulse while `busy` is 1 is ignored, and any change to `thr` during that time has no effect on the slice in progress.
- R9: The fire flag is sticky. A threshold of 0 fires whenever any product is 1, and counting past overflow never clears the flag. A threshold above INPUTS never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a slice and samples the thresholds when the block is idle |
| thr | input | NEURONS*CW | Thresholds for this slice, one CW-bit field per neuron |
| wt_in | input | 1 | Serial weight bit, neuron 0 first within each input group |
| x_in | input | 1 | Shared input bit, sampled while `in_phase` is 1 |
| busy | output | 1 | A slice is in progress |
| in_phase | output | 1 | This cycle samples `x_in` and updates the counters |
| done | output | 1 | One-cycle strobe; the output register holds this slice's results |
| out_bit | output | 1 | Serial neuron results, neuron 0 first |

## Verification
The assertions assume that `start` is pulsed only with the block idle, or that any pulse during a slice is meant to be ignored. They also assume that `wt_in`, `x_in` and `thr` are stable around the clock edge. The bench drives every input on the falling edge. It holds its own cycle count per slice, so that each weight bit and input bit lands on the edge the protocol assigns to it. One run deliberately pulses `start` and scrambles `thr` in the middle of a slice, so that the ignore path is exercised without breaking the timing assumptions.

// File: rtl/stoch_neuron_layer.sv
module stoch_neuron_layer #(
  parameter int NEURONS = 4,
  parameter int INPUTS  = 6,
  parameter int CW      = $clog2(INPUTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NEURONS*CW-1:0] thr,
  input  logic                  wt_in,
  input  logic                  x_in,
  output logic                  busy,
  output logic                  in_phase,
  output logic                  done,
  output logic                  out_bit
);
  localparam int PW = $clog2(NEURONS + 1);
  localparam int IW = $clog2(INPUTS + 1);

  logic [PW-1:0]      pos;
  logic [IW-1:0]      idx;
  logic [NEURONS-1:0] wreg, fire, fire_nx, oreg;
  logic               launch, last;

  assign launch   = start && !busy;
  assign in_phase = busy && (pos == PW'(NEURONS));
  assign last     = in_phase && (idx == IW'(INPUTS - 1));
  assign out_bit  = oreg[0];

  for (genvar g = 0; g < NEURONS; g++) begin : g_cell
    logic [CW-1:0] cnt;
    logic          prod;
    assign prod       = ~(x_in ^ wreg[g]);
    assign fire_nx[g] = fire[g] | (prod & (cnt == '1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt     <= '0;
        fire[g] <= 1'b0;
      end else if (launch) begin
        cnt     <= '1 - thr[g*CW +: CW];
        fire[g] <= 1'b0;
      end else if (in_phase) begin
        cnt     <= cnt + CW'(prod);
        fire[g] <= fire_nx[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pos  <= '0;
      idx  <= '0;
      wreg <= '0;
      oreg <= '0;
    end else begin
      done <= 1'b0;
      oreg <= oreg >> 1;
      if (launch) begin
        busy <= 1'b1;
        pos  <= '0;
        idx  <= '0;
      end else if (in_phase) begin
        pos <= '0;
        idx <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          oreg <= fire_nx;
        end
      end else if (busy) begin
        pos  <= pos + 1'b1;
        wreg <= (wreg >> 1) | (NEURONS'(wt_in) << (NEURONS - 1));
      end
    end
  end
endmodule

module stoch_neuron_layer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic in_phase,
  input logic done,
  input logic out_bit
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !done && !busy);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_busy_falls_done_R6: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_sample_in_slice_R3: assert property (@(posedge clk) disable iff (!rst_n) in_phase |-> busy);
  assert_sample_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n) in_phase |=> !in_phase);
  assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy && !in_phase);
  assert_held_busy_R8: assert property (@(posedge clk) disable iff (!rst_n) busy && !in_phase |=> busy);
endmodule

bind stoch_neuron_layer stoch_neuron_layer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .in_phase(in_phase), .done(done), .out_bit(out_bit)
);

// File: tb/stoch_neuron_layer_test.sv
`timescale 1ns/1ps
module stoch_neuron_layer_test;
  localparam int N  = 3;
  localparam int I  = 5;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0, start = 0, wt_in = 0, x_in = 0;
  logic [N*CW-1:0] thr = '0;
  logic busy, in_phase, done, out_bit;
  int checks = 0, fails = 0;

  logic w [N][I];
  logic x [I];
  int   th [N];

  always #4 clk = ~clk;

  stoch_neuron_layer #(.NEURONS(N), .INPUTS(I), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .thr(thr), .wt_in(wt_in),
    .x_in(x_in), .busy(busy), .in_phase(in_phase), .done(done), .out_bit(out_bit));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_slice(input bit disturb);
    for (int n = 0; n < N; n++) thr[n*CW +: CW] = CW'(th[n]);
    start = 1;
    @(negedge clk);
    start = 0;
    for (int j = 0; j < I; j++) begin
      for (int k = 0; k < N; k++) begin
        wt_in = w[k][j];
        if (disturb && j == 2 && k == 1) begin
          start = 1;
          thr = ~thr;
        end
        chk(in_phase == 0 && busy == 1, "R2 weight cycle", in_phase, 0);
        @(negedge clk);
        start = 0;
      end
      x_in = x[j];
      chk(in_phase == 1, "R3 sample cycle", in_phase, 1);
      chk(done == 0, "R6 early done", done, 0);
      @(negedge clk);
    end
    chk(done == 1 && busy == 0, "R6 done timing", done, 1);
    for (int n = 0; n < N; n++) begin
      int ones = 0;
      int exp;
      for (int j = 0; j < I; j++) ones += (x[j] ~^ w[n][j]) ? 1 : 0;
      exp = (ones > th[n]) ? 1 : 0;
      chk(out_bit == exp, disturb ? "R8 ignored start" : "R4 R7 fire", out_bit, exp);
      @(negedge clk);
      chk(done == 0, "R6 single strobe", done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(7));
    #1;
    chk(busy == 0 && in_phase == 0 && done == 0 && out_bit == 0, "R1 reset", busy, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && out_bit == 0, "R1 idle", busy, 0);
    // R9: all products 1, then all 0, thresholds across full range
    for (int t = 0; t < 8; t++) begin
      for (int m = 0; m < 2; m++) begin
        for (int j = 0; j < I; j++) begin
          x[j] = j[0];
          for (int n = 0; n < N; n++) w[n][j] = m ? ~j[0] : j[0];
        end
        for (int n = 0; n < N; n++) th[n] = t;
        run_slice(0);
      end
    end
    // R2: one neuron matching at a time, distinguishes neuron order
    for (int s = 0; s < N; s++) begin
      for (int j = 0; j < I; j++) begin
        x[j] = 1;
        for (int n = 0; n < N; n++) w[n][j] = (n == s);
      end
      for (int n = 0; n < N; n++) th[n] = 0;
      run_slice(0);
    end
    // R4 R5: random patterns with thresholds varied per slice
    for (int s = 0; s < 240; s++) begin
      for (int j = 0; j < I; j++) begin
        x[j] = $urandom_range(1);
        for (int n = 0; n < N; n++) w[n][j] = $urandom_range(1);
      end
      for (int n = 0; n < N; n++) th[n] = (s + n * 3) % 7;
      run_slice(0);
      if (s % 3 == 0) @(negedge clk);
    end
    // R8: start and thr scrambled mid-slice
    for (int s = 0; s < 12; s++) begin
      for (int j = 0; j < I; j++) begin
        x[j] = $urandom_range(1);
        for (int n = 0; n < N; n++) w[n][j] = $urandom_range(1);
      end
      for (int n = 0; n < N; n++) th[n] = (s + n) % 6;
      run_slice(1);
    end
    chk(busy == 0 && out_bit == 0, "R7 drained", out_bit, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule